// File: doc/BRIEF.md
# Split-Phase Tagged Bus Interconnect

This block connects one bus master to four memory-like slaves. The master does not wait for one transaction to finish before starting the next. It pushes read and write requests, each with a tag, into a request queue. Later it pops tagged responses from a response queue. The address of each request selects exactly one slave. Addresses that fall inside no slave's window get an error response and reach no slave.

Requests leave the request queue in the order they were pushed. Slaves have different latencies, so responses can come back in a different order from the requests. The master matches each response to its request by tag. If several slaves hold finished responses at the same time, a rotating choice picks which one enters the response queue. The others keep their responses until they are taken. A write response carries no data. It still returns the tag and a status bit, so the master can retire the write.

Top module: `split_bus`

## Requirements
- R1: After reset, req_full is 0 and rsp_empty is 1.
- R2: A read to a mapped address returns rsp_err=0 and rsp_wr=0, with the request's tag. Its rsp_rdata is the value of the last write to the same word of the same slave, or 0 if that word has not been written.
- R3: A write to a mapped address returns rsp_wr=1, rsp_err=0 and rsp_rdata=0, with the request's tag.
- R4: Slave i owns the addresses from base_i up to, but not including, base_i+size_i. The defaults are bases 0x0000, 0x0100, 0x0200, 0x0400 and size 0x10 each. The word inside the slave is addr-base_i. A request is delivered only to the slave that owns its address.
- R5: An address owned by no slave returns rsp_err=1 and rsp_rdata=0, with the request's tag and its rsp_wr value. No slave's storage changes.
- R6: Slave latencies differ (defaults 6, 1, 3 and 2 cycles for slaves 0 to 3). A later request to an idle slave is issued while an earlier request is still outstanding, and its response may leave first.
- R7: The request queue holds 8 entries, and req_full is 1 exactly when it holds 8. The master pushes only while req_full is 0.
- R8: The response queue holds 8 entries. While it is full, finished slaves hold their responses. No response is lost or duplicated, and every request gets exactly one response.
- R9: When several responders hold a response in the same cycle, a rotating choice takes one of them. Each responder not taken keeps its response unchanged until it is taken.
- R10: Requests leave the request queue in push order. A request whose target slave is busy waits at the head of the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_push | input | 1 | Pushes a request this cycle |
| req_addr | input | 16 | Word address of the request |
| req_wdata | input | 32 | Write data |
| req_tag | input | 4 | Transaction tag |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_full | output | 1 | Request queue is full |
| rsp_pop | input | 1 | Pops the head response |
| rsp_rdata | output | 32 | Read data of the head response |
| rsp_tag | output | 4 | Tag of the head response |
| rsp_wr | output | 1 | Head response answers a write |
| rsp_err | output | 1 | Head response reports an unmapped address |
| rsp_empty | output | 1 | Response queue is empty |

## Verification
The hardest case to reach is slaves holding finished responses while the response queue is full. A second hard case is several responders being ready at the same time. The bench reaches both by spreading twelve requests over all four slaves and the unmapped range without popping anything. It waits long enough for every slave to finish, then drains the queue, and checks that each tag comes back exactly once with the right data. The out-of-order case comes from a read to the slowest slave followed by a read to the fastest one. Unmapped writes and reads use addresses whose low bits alias real words, so a response that went to the wrong slave shows up as changed read data.

// File: rtl/sbus_pkg.sv
// Shared widths and transaction types for the split-phase interconnect.
package sbus_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 32;
    parameter int TAG_W  = 4;

    typedef struct packed {
        logic              wr;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic              err;
        logic              wr;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] rdata;
    } rsp_t;
endpackage

// File: rtl/sbus_fifo.sv
// Synchronous show-ahead FIFO. The head entry is visible on dout while empty is 0.
// Assumes the user never pushes when full and never pops when empty.
module sbus_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    output logic             full,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0]   count;
    logic             do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign full    = (count == (PTR_W+1)'(DEPTH));
    assign empty   = (count == '0);
    assign dout    = mem[rd_ptr];

    // Store the pushed entry.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7 / R8: occupancy never exceeds the depth.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (PTR_W+1)'(DEPTH));
    // R8: a lone accepted push adds exactly one entry.
    assert_push_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/sbus_slave.sv
// Memory-like slave. It takes one request at a time and waits LAT cycles.
// Then it performs the read or write and holds the response until granted.
// Assumes LAT >= 1 and that requests are only offered while ready is 1.
module sbus_slave
    import sbus_pkg::*;
#(
    parameter int                WORDS = 16,
    parameter logic [ADDR_W-1:0] BASE  = '0,
    parameter int                LAT   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_valid,
    input  req_t acc_req,
    output logic ready,
    output logic rsp_valid,
    output rsp_t rsp,
    input  logic rsp_grant
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int CNT_W = $clog2(LAT + 1) + 1;

    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} sl_state_t;

    sl_state_t        state;
    req_t             held;
    logic [CNT_W-1:0] cnt;
    logic [DATA_W-1:0] store [WORDS];
    logic [ADDR_W-1:0] offs;
    logic [IDX_W-1:0]  idx;

    assign offs      = held.addr - BASE;
    assign idx       = offs[IDX_W-1:0];
    assign ready     = (state == S_IDLE);
    assign rsp_valid = (state == S_DONE);

    // Accept, count down the latency, perform the access, hold the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            held  <= '0;
            cnt   <= '0;
            rsp   <= '0;
            for (int w = 0; w < WORDS; w++) store[w] <= '0;
        end else begin
            case (state)
                S_IDLE: if (acc_valid) begin
                    held  <= acc_req;
                    cnt   <= CNT_W'(LAT);
                    state <= S_WAIT;
                end
                S_WAIT: if (cnt <= CNT_W'(1)) begin
                    rsp.err <= 1'b0;
                    rsp.wr  <= held.wr;
                    rsp.tag <= held.tag;
                    if (held.wr) begin
                        store[idx] <= held.wdata;
                        rsp.rdata  <= '0;
                    end else begin
                        rsp.rdata  <= store[idx];
                    end
                    state <= S_DONE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                S_DONE: if (rsp_grant) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R9: a response that is not taken stays valid and unchanged.
    assert_hold_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_grant) |=> (rsp_valid && $stable(rsp)));
    // R10: a request is only delivered to an idle slave.
    assert_accept_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> ready);
endmodule

// File: rtl/sbus_rr_arb.sv
// Rotating arbiter. Searching starts just after the most recent winner.
// Grants nothing while en is 0.
module sbus_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] last;
    logic [PW-1:0] win;

    // Pick the first requester after the previous winner.
    always_comb begin
        int idx;
        grant = '0;
        win   = last;
        for (int off = 1; off <= N; off++) begin
            idx = int'(last) + off;
            if (idx >= N) idx = idx - N;
            if (en && (grant == '0) && req[idx[PW-1:0]]) begin
                grant[idx[PW-1:0]] = 1'b1;
                win                = idx[PW-1:0];
            end
        end
    end

    // Remember the winner so that it has lowest priority next time.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= PW'(N-1);
        else if (grant != '0) last <= win;
    end

    // R9: at most one winner, and only among requesters.
    assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0));
    // R9: with the output enabled, a pending requester is always served.
    assert_grant_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (req != '0)) |-> (grant != '0));
endmodule

// File: rtl/split_bus.sv
// Split-phase tagged interconnect: one master, NSLV memory-like slaves.
// Requests issue in push order to the slave owning the address. Unmapped
// addresses get an error response. Finished responses are merged into the
// response queue by a rotating arbiter.
// Assumes slave windows do not overlap and tags in flight are unique.
module split_bus
    import sbus_pkg::*;
#(
    parameter int                       NSLV     = 4,
    parameter int                       QDEPTH   = 8,
    parameter int                       WORDS    = 16,
    parameter logic [NSLV*ADDR_W-1:0]   SLV_BASE = {16'h0400, 16'h0200, 16'h0100, 16'h0000},
    parameter logic [NSLV*ADDR_W-1:0]   SLV_SIZE = {16'h0010, 16'h0010, 16'h0010, 16'h0010},
    parameter logic [NSLV*8-1:0]        SLV_LAT  = {8'd2, 8'd3, 8'd1, 8'd6}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_push,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              req_wr,
    output logic              req_full,
    input  logic              rsp_pop,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_wr,
    output logic              rsp_err,
    output logic              rsp_empty
);
    localparam int NRESP = NSLV + 1;
    localparam int ERR_I = NSLV;

    req_t             req_in, head;
    logic             req_empty, dispatch;
    logic [NSLV-1:0]  hit, slv_ready, acc_valid;
    logic             miss, tgt_ready;
    logic [NRESP-1:0] resp_valid, grant;
    rsp_t             resp [NRESP];
    rsp_t             rsp_in, rsp_out;
    logic             rsp_full, err_valid;
    rsp_t             err_rsp;

    assign req_in = '{wr: req_wr, tag: req_tag, addr: req_addr, wdata: req_wdata};

    sbus_fifo #(.WIDTH($bits(req_t)), .DEPTH(QDEPTH)) u_reqq (
        .clk(clk), .rst_n(rst_n), .push(req_push), .din(req_in), .full(req_full),
        .pop(dispatch), .dout(head), .empty(req_empty)
    );

    // Window decode for the head request.
    generate
        for (genvar i = 0; i < NSLV; i++) begin : g_dec
            localparam logic [ADDR_W-1:0] B = SLV_BASE[i*ADDR_W +: ADDR_W];
            localparam logic [ADDR_W-1:0] S = SLV_SIZE[i*ADDR_W +: ADDR_W];
            logic [ADDR_W-1:0] rel;
            assign rel    = head.addr - B;
            assign hit[i] = (head.addr >= B) && (rel < S);
        end
    endgenerate
    assign miss = (hit == '0);

    // Issue the head only when its single target can take it.
    assign tgt_ready = miss ? !err_valid : ((hit & slv_ready) != '0);
    assign dispatch  = !req_empty && tgt_ready;
    assign acc_valid = dispatch ? hit : '0;

    // One slave per window.
    generate
        for (genvar i = 0; i < NSLV; i++) begin : g_slv
            sbus_slave #(
                .WORDS(WORDS),
                .BASE (SLV_BASE[i*ADDR_W +: ADDR_W]),
                .LAT  (int'(SLV_LAT[i*8 +: 8]))
            ) u_slv (
                .clk(clk), .rst_n(rst_n),
                .acc_valid(acc_valid[i]), .acc_req(head), .ready(slv_ready[i]),
                .rsp_valid(resp_valid[i]), .rsp(resp[i]), .rsp_grant(grant[i])
            );
        end
    endgenerate

    // Error responder: one slot, filled by an unmapped request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_rsp   <= '0;
        end else if (dispatch && miss) begin
            err_valid <= 1'b1;
            err_rsp   <= '{err: 1'b1, wr: head.wr, tag: head.tag, rdata: '0};
        end else if (grant[ERR_I]) begin
            err_valid <= 1'b0;
        end
    end
    assign resp_valid[ERR_I] = err_valid;
    assign resp[ERR_I]       = err_rsp;

    sbus_rr_arb #(.N(NRESP)) u_arb (
        .clk(clk), .rst_n(rst_n), .en(!rsp_full), .req(resp_valid), .grant(grant)
    );

    // Route the granted response into the response queue.
    always_comb begin
        rsp_in = '0;
        for (int i = 0; i < NRESP; i++) if (grant[i]) rsp_in = resp[i];
    end

    sbus_fifo #(.WIDTH($bits(rsp_t)), .DEPTH(QDEPTH)) u_rspq (
        .clk(clk), .rst_n(rst_n), .push(grant != '0), .din(rsp_in), .full(rsp_full),
        .pop(rsp_pop), .dout(rsp_out), .empty(rsp_empty)
    );

    assign rsp_rdata = rsp_out.rdata;
    assign rsp_tag   = rsp_out.tag;
    assign rsp_wr    = rsp_out.wr;
    assign rsp_err   = rsp_out.err;

    // R4: windows never overlap, so at most one slave matches.
    assert_single_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_empty |-> $onehot0(hit));
    // R5: an unmapped request is given to no slave.
    assert_miss_no_slave_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dispatch && miss) |-> (acc_valid == '0));
    // R5: the error slot always reports an error.
    assert_err_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> err_rsp.err);
    // R8: nothing enters a full response queue.
    assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_full |-> (grant == '0));
endmodule

// File: tb/tb_split_bus.sv
module tb_split_bus;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_push = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_tag = '0;
    logic        req_wr = 1'b0;
    logic        req_full;
    logic        rsp_pop = 1'b0;
    logic [31:0] rsp_rdata;
    logic [3:0]  rsp_tag;
    logic        rsp_wr, rsp_err, rsp_empty;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit saw_full = 1'b0;

    // Reference model: slave storage and expectation per tag.
    logic [31:0] model [4][16];
    logic [31:0] exp_data [16];
    bit          exp_err [16];
    bit          exp_wr [16];
    bit          pend [16];

    always #5 clk = ~clk;

    split_bus dut (
        .clk(clk), .rst_n(rst_n), .req_push(req_push), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_tag(req_tag), .req_wr(req_wr), .req_full(req_full),
        .rsp_pop(rsp_pop), .rsp_rdata(rsp_rdata), .rsp_tag(rsp_tag), .rsp_wr(rsp_wr),
        .rsp_err(rsp_err), .rsp_empty(rsp_empty)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int owner(input logic [15:0] a);
        logic [15:0] bases [4];
        bases = '{16'h0000, 16'h0100, 16'h0200, 16'h0400};
        for (int s = 0; s < 4; s++) if (a >= bases[s] && a - bases[s] < 16'h10) return s;
        return -1;
    endfunction

    // Push one request and record what its response must be.
    task automatic push_req(input logic [15:0] a, input logic [31:0] d, input logic [3:0] t, input bit w);
        int s;
        @(negedge clk);
        while (req_full) begin saw_full = 1'b1; @(negedge clk); end
        req_push = 1'b1; req_addr = a; req_wdata = d; req_tag = t; req_wr = w;
        s = owner(a);
        pend[t] = 1'b1; exp_wr[t] = w; exp_err[t] = (s < 0); exp_data[t] = '0;
        if (s >= 0) begin
            if (w) model[s][a[3:0]] = d;
            else   exp_data[t] = model[s][a[3:0]];
        end
        @(posedge clk);
        #1 req_push = 1'b0;
    endtask

    // Pop one response and compare it with the expectation for its tag.
    task automatic pop_check(input string req);
        logic [3:0] t;
        @(negedge clk);
        while (rsp_empty) @(negedge clk);
        t = rsp_tag;
        chk(pend[t], {req, " tag outstanding"}, 32'(t), 32'(t));
        chk(rsp_err == exp_err[t], {req, " err"}, 32'(rsp_err), 32'(exp_err[t]));
        chk(rsp_wr == exp_wr[t], {req, " wr"}, 32'(rsp_wr), 32'(exp_wr[t]));
        chk(rsp_rdata == exp_data[t], {req, " rdata"}, rsp_rdata, exp_data[t]);
        pend[t] = 1'b0;
        rsp_pop = 1'b1;
        @(posedge clk);
        #1 rsp_pop = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_full == 1'b0, "R1 req_full", 32'(req_full), 32'd0);
        chk(rsp_empty == 1'b1, "R1 rsp_empty", 32'(rsp_empty), 32'd1);
    endtask

    task automatic t_write_read();
        push_req(16'h0203, 32'hA5A5_1234, 4'd1, 1'b1);
        pop_check("R3 write response");
        push_req(16'h0203, 32'h0, 4'd2, 1'b0);
        pop_check("R2 read back");
        push_req(16'h0405, 32'h0, 4'd3, 1'b0);
        pop_check("R2 unwritten word");
    endtask

    task automatic t_decode();
        push_req(16'h0000, 32'h1111_0000, 4'd4, 1'b1);
        push_req(16'h0100, 32'h2222_0000, 4'd5, 1'b1);
        push_req(16'h040F, 32'h3333_000F, 4'd6, 1'b1);
        pop_check("R4 write"); pop_check("R4 write"); pop_check("R4 write");
        push_req(16'h0000, 32'h0, 4'd7, 1'b0);
        push_req(16'h0100, 32'h0, 4'd8, 1'b0);
        push_req(16'h040F, 32'h0, 4'd9, 1'b0);
        push_req(16'h0200, 32'h0, 4'd10, 1'b0);
        pop_check("R4 isolation"); pop_check("R4 isolation");
        pop_check("R4 isolation"); pop_check("R4 isolation");
    endtask

    task automatic t_unmapped();
        push_req(16'h0110, 32'hDEAD_BEEF, 4'd11, 1'b1);
        pop_check("R5 unmapped write");
        push_req(16'h0300, 32'h0, 4'd12, 1'b0);
        pop_check("R5 unmapped read");
        push_req(16'h0100, 32'h0, 4'd13, 1'b0);
        pop_check("R5 slave unchanged");
    endtask

    task automatic t_out_of_order();
        push_req(16'h0000, 32'h0, 4'd1, 1'b0);
        push_req(16'h0100, 32'h0, 4'd2, 1'b0);
        @(negedge clk);
        while (rsp_empty) @(negedge clk);
        chk(rsp_tag == 4'd2, "R6 fast slave first", 32'(rsp_tag), 32'd2);
        pop_check("R6 fast");
        pop_check("R6 slow");
    endtask

    task automatic t_req_full();
        saw_full = 1'b0;
        for (int k = 0; k < 10; k++) push_req(16'h0001, 32'h0, 4'(k), 1'b0);
        chk(saw_full == 1'b1, "R7 req_full reached", 32'(saw_full), 32'd1);
        for (int k = 0; k < 10; k++) pop_check("R10 queued issue");
    endtask

    task automatic t_backpressure();
        for (int k = 0; k < 12; k++) begin
            logic [15:0] a;
            case (k % 5)
                0: a = 16'h0002;
                1: a = 16'h0102;
                2: a = 16'h0202;
                3: a = 16'h0402;
                default: a = 16'h0800;
            endcase
            push_req(a, 32'hC000_0000 + 32'(k), 4'(k), (k < 5));
        end
        repeat (200) @(negedge clk);
        chk(rsp_empty == 1'b0, "R8 responses held", 32'(rsp_empty), 32'd0);
        for (int k = 0; k < 12; k++) pop_check("R8 R9 drain");
        for (int k = 0; k < 12; k++)
            chk(pend[k] == 1'b0, "R8 every tag answered", 32'(pend[k]), 32'd0);
        repeat (20) @(negedge clk);
        chk(rsp_empty == 1'b1, "R8 no duplicate", 32'(rsp_empty), 32'd1);
    endtask

    initial begin
        for (int s = 0; s < 4; s++) for (int w = 0; w < 16; w++) model[s][w] = '0;
        for (int t = 0; t < 16; t++) pend[t] = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_decode();
        t_unmapped();
        t_out_of_order();
        t_req_full();
        t_backpressure();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule